// File: doc/BRIEF.md
# Frame-Synchronised Window Configuration Bank

This block keeps the configuration of each display overlay window in two copies. Software writes a working copy through a simple register port. The scan-out path sees only the active copy. The active copy is reloaded from the working copy only on a vsync pulse, so a frame is never built from a mix of old and new settings. Each window carries an enable, a pixel-format code, a frame-buffer start address and an overlay rectangle. Window 1 also carries a colour-key enable and a key value.

A transfer has to be armed by writing an update bit. Each window also has a hold bit. While a window's hold bit is set, an armed vsync skips that window and marks it as deferred. A deferred window loads at the first vsync after its hold bit is cleared, with no need to arm again. Software therefore sets the hold bit, rewrites several registers, clears the hold bit and arms, and the window changes in one step. A window that is switched off keeps showing until the next transfer.

Register address bits: bit 5 selects the active (read-only) view, bits [4:3] select the page (window number, or 3 for the global page) and bits [2:0] select the offset.

Top module: `shadow_bank`

## Requirements
- R1: Active outputs change only on a clock edge where `vsync` is high.
- R2: Writing 1 in bit 0 at global offset 1 (address 0x19) arms a transfer. Bit 0 of that register reads back as 1 while the transfer is armed. An armed vsync loads every window whose hold bit is clear and clears the armed bit.
- R3: A vsync with nothing armed and nothing deferred leaves every active copy unchanged.
- R4: Global offset 0 (address 0x18) holds one hold bit per window, bit w for window w. A held window is not loaded by an armed vsync, and its deferred flag is set. The flag reads back at bit 1+w of address 0x19.
- R5: A deferred window whose hold bit is clear loads at the next vsync without re-arming. This clears its deferred flag.
- R6: Clearing a window's enable bit (offset 0, bit 0) does not change its active enable until a transfer loads that window.
- R7: A read with address bit 5 clear returns the working copy. A read with bit 5 set returns the active copy. Field positions are:
  - offset 0: enable in bit 0 and format in bits [7:4]
  - offset 1: start address in bits [31:0]
  - offset 2: top-left x in bits [11:0] and y in bits [27:16]
  - offset 3: bottom-right x and y, in the same positions; the coordinates are inclusive
  - offset 4: key enable in bit 0
  - offset 5: key value in bits [23:0]
- R8: Window 0 has no colour key. Writes to its offsets 4 and 5 have no effect, and those offsets read 0. Window 1's key fields are stored, read back and transferred.
- R9: A write in the same cycle as vsync lands in the working copy, while that vsync transfers the previous working value. An arm write in the same cycle as vsync arms the following vsync.
- R10: After reset, all working fields, active fields, hold bits, deferred flags and the armed bit are 0.
- R11: Writes with address bit 5 set change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Frame boundary pulse, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| act_en | output | NUM_WIN | Active enable per window |
| act_fmt | output | NUM_WIN*4 | Active pixel format per window |
| act_base | output | NUM_WIN*32 | Active buffer start per window |
| act_tlx | output | NUM_WIN*12 | Active top-left x |
| act_tly | output | NUM_WIN*12 | Active top-left y |
| act_brx | output | NUM_WIN*12 | Active bottom-right x, inclusive |
| act_bry | output | NUM_WIN*12 | Active bottom-right y, inclusive |
| act_key_en | output | NUM_WIN | Active colour-key enable (0 for window 0) |
| act_key_val | output | NUM_WIN*24 | Active colour-key value (0 for window 0) |

## Verification
The bench builds the block with two windows, 12-bit coordinates, 32-bit addresses and 24-bit key values. With these values, every window page, the global page and the unused third page are reachable through the 6-bit address. Window 0 is keyless and window 1 is keyed, so both variants of the per-window generate are in the build. Two windows are enough to hold one window while the other loads, which is where the deferred path and the coincident write-with-vsync cases become visible.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  parameter int DATA_W  = 32;
  parameter int REG_AW  = 6;
  parameter int OFF_W   = 3;
  parameter int PG_W    = 2;
  parameter int BUF_W   = 32;
  parameter int COORD_W = 12;
  parameter int FMT_W   = 4;
  parameter int KEY_W   = 24;

  localparam int FMT_LSB = 4;
  localparam int Y_LSB   = 16;
  localparam int GLOB_PG = (1 << PG_W) - 1;

  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_BASE = 3'd1;
  localparam logic [OFF_W-1:0] OFF_TL   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_BR   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_KCTL = 3'd4;
  localparam logic [OFF_W-1:0] OFF_KVAL = 3'd5;
  localparam logic [OFF_W-1:0] GOFF_HOLD = 3'd0;
  localparam logic [OFF_W-1:0] GOFF_UPD  = 3'd1;

  typedef struct packed {
    logic               en;
    logic [FMT_W-1:0]   fmt;
    logic [BUF_W-1:0]   base;
    logic [COORD_W-1:0] tlx;
    logic [COORD_W-1:0] tly;
    logic [COORD_W-1:0] brx;
    logic [COORD_W-1:0] bry;
    logic               key_en;
    logic [KEY_W-1:0]   key_val;
  } win_cfg_t;

  function automatic logic [DATA_W-1:0] cfg_word(win_cfg_t c, logic [OFF_W-1:0] off);
    logic [DATA_W-1:0] w;
    w = '0;
    case (off)
      OFF_CTRL: begin
        w[0] = c.en;
        w[FMT_LSB +: FMT_W] = c.fmt;
      end
      OFF_BASE: w[BUF_W-1:0] = c.base;
      OFF_TL: begin
        w[COORD_W-1:0] = c.tlx;
        w[Y_LSB +: COORD_W] = c.tly;
      end
      OFF_BR: begin
        w[COORD_W-1:0] = c.brx;
        w[Y_LSB +: COORD_W] = c.bry;
      end
      OFF_KCTL: w[0] = c.key_en;
      OFF_KVAL: w[KEY_W-1:0] = c.key_val;
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/shadow_win.sv
module shadow_win
  import shadow_bank_pkg::*;
#(
  parameter bit HAS_KEY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output win_cfg_t          wrk,
  output win_cfg_t          act
);
  win_cfg_t wrk_n;

  always_comb begin
    wrk_n = wrk;
    case (wr_off)
      OFF_CTRL: begin
        wrk_n.en  = wr_data[0];
        wrk_n.fmt = wr_data[FMT_LSB +: FMT_W];
      end
      OFF_BASE: wrk_n.base = wr_data[BUF_W-1:0];
      OFF_TL: begin
        wrk_n.tlx = wr_data[COORD_W-1:0];
        wrk_n.tly = wr_data[Y_LSB +: COORD_W];
      end
      OFF_BR: begin
        wrk_n.brx = wr_data[COORD_W-1:0];
        wrk_n.bry = wr_data[Y_LSB +: COORD_W];
      end
      OFF_KCTL: if (HAS_KEY) wrk_n.key_en = wr_data[0];
      OFF_KVAL: if (HAS_KEY) wrk_n.key_val = wr_data[KEY_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrk <= '0;
      act <= '0;
    end else begin
      if (wr_stb) wrk <= wrk_n;
      if (load)   act <= wrk;
    end
  end
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl #(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               hold_wr,
  input  logic [NUM_WIN-1:0] hold_data,
  input  logic               arm_wr,
  output logic [NUM_WIN-1:0] load,
  output logic [NUM_WIN-1:0] hold_q,
  output logic [NUM_WIN-1:0] def_q,
  output logic               armed_q
);
  logic [NUM_WIN-1:0] def_n;
  logic               armed_n;

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) begin
      load[w]  = vsync && !hold_q[w] && (armed_q || def_q[w]);
      def_n[w] = vsync ? ((armed_q || def_q[w]) && hold_q[w]) : def_q[w];
    end
    armed_n = arm_wr ? 1'b1 : (vsync ? 1'b0 : armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      def_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (hold_wr) hold_q <= hold_data;
      def_q   <= def_n;
      armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vsync,
  input  logic                       wr_en,
  input  logic [REG_AW-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [REG_AW-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_WIN-1:0]         act_en,
  output logic [NUM_WIN*FMT_W-1:0]   act_fmt,
  output logic [NUM_WIN*BUF_W-1:0]   act_base,
  output logic [NUM_WIN*COORD_W-1:0] act_tlx,
  output logic [NUM_WIN*COORD_W-1:0] act_tly,
  output logic [NUM_WIN*COORD_W-1:0] act_brx,
  output logic [NUM_WIN*COORD_W-1:0] act_bry,
  output logic [NUM_WIN-1:0]         act_key_en,
  output logic [NUM_WIN*KEY_W-1:0]   act_key_val
);
  logic              wr_act, rd_act;
  logic [PG_W-1:0]   wr_pg, rd_pg;
  logic [OFF_W-1:0]  wr_off, rd_off;
  logic              glob_wr, hold_wr, arm_wr;
  logic [NUM_WIN-1:0] win_stb, load, hold_q, def_q;
  logic              armed_q;
  win_cfg_t [NUM_WIN-1:0] wrk_cfg;
  win_cfg_t [NUM_WIN-1:0] act_cfg;

  assign wr_act  = wr_addr[REG_AW-1];
  assign wr_pg   = wr_addr[OFF_W +: PG_W];
  assign wr_off  = wr_addr[OFF_W-1:0];
  assign rd_act  = rd_addr[REG_AW-1];
  assign rd_pg   = rd_addr[OFF_W +: PG_W];
  assign rd_off  = rd_addr[OFF_W-1:0];
  assign glob_wr = wr_en && !wr_act && (wr_pg == PG_W'(GLOB_PG));
  assign hold_wr = glob_wr && (wr_off == GOFF_HOLD);
  assign arm_wr  = glob_wr && (wr_off == GOFF_UPD) && wr_data[0];

  shadow_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .hold_wr   (hold_wr),
    .hold_data (wr_data[NUM_WIN-1:0]),
    .arm_wr    (arm_wr),
    .load      (load),
    .hold_q    (hold_q),
    .def_q     (def_q),
    .armed_q   (armed_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_stb[w] = wr_en && !wr_act && (wr_pg == PG_W'(w));

    shadow_win #(.HAS_KEY(w != 0)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (win_stb[w]),
      .wr_off  (wr_off),
      .wr_data (wr_data),
      .load    (load[w]),
      .wrk     (wrk_cfg[w]),
      .act     (act_cfg[w])
    );

    assign act_en[w]                         = act_cfg[w].en;
    assign act_fmt[w*FMT_W +: FMT_W]         = act_cfg[w].fmt;
    assign act_base[w*BUF_W +: BUF_W]        = act_cfg[w].base;
    assign act_tlx[w*COORD_W +: COORD_W]     = act_cfg[w].tlx;
    assign act_tly[w*COORD_W +: COORD_W]     = act_cfg[w].tly;
    assign act_brx[w*COORD_W +: COORD_W]     = act_cfg[w].brx;
    assign act_bry[w*COORD_W +: COORD_W]     = act_cfg[w].bry;
    assign act_key_en[w]                     = act_cfg[w].key_en;
    assign act_key_val[w*KEY_W +: KEY_W]     = act_cfg[w].key_val;
  end

  always_comb begin
    rd_data = '0;
    if (!rd_act && rd_pg == PG_W'(GLOB_PG)) begin
      case (rd_off)
        GOFF_HOLD: rd_data[NUM_WIN-1:0] = hold_q;
        GOFF_UPD:  rd_data[NUM_WIN:0]   = {def_q, armed_q};
        default: ;
      endcase
    end
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rd_pg == PG_W'(w))
        rd_data = cfg_word(rd_act ? act_cfg[w] : wrk_cfg[w], rd_off);
    end
  end
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vsync,
  input logic                   arm_wr,
  input logic                   armed_q,
  input logic [NUM_WIN-1:0]     hold_q,
  input logic [NUM_WIN-1:0]     def_q,
  input win_cfg_t [NUM_WIN-1:0] wrk_cfg,
  input win_cfg_t [NUM_WIN-1:0] act_cfg
);
  assert_active_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_cfg));

  assert_arm_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> armed_q);

  assert_arm_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !arm_wr) |=> !armed_q);

  assert_idle_vsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !armed_q && def_q == '0) |=> $stable(act_cfg));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    assert_hold_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hold_q[w]) |=> $stable(act_cfg[w]));

    assert_defer_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hold_q[w] && armed_q) |=> def_q[w]);

    assert_defer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !hold_q[w] && def_q[w]) |=> (act_cfg[w] == $past(wrk_cfg[w]) && !def_q[w]));
  end
endmodule

bind shadow_bank shadow_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vsync   (vsync),
  .arm_wr  (arm_wr),
  .armed_q (armed_q),
  .hold_q  (hold_q),
  .def_q   (def_q),
  .wrk_cfg (wrk_cfg),
  .act_cfg (act_cfg)
);

// File: tb/sim_shadow_bank.sv
module sim_shadow_bank;
  localparam int NW = 2;

  logic clk, rst_n, vsync, wr_en;
  logic [5:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [NW-1:0]    act_en, act_key_en;
  logic [NW*4-1:0]  act_fmt;
  logic [NW*32-1:0] act_base;
  logic [NW*12-1:0] act_tlx, act_tly, act_brx, act_bry;
  logic [NW*24-1:0] act_key_val;

  int checks = 0;
  int fails  = 0;

  shadow_bank #(.NUM_WIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .act_en(act_en),
    .act_fmt(act_fmt), .act_base(act_base), .act_tlx(act_tlx), .act_tly(act_tly),
    .act_brx(act_brx), .act_bry(act_bry), .act_key_en(act_key_en),
    .act_key_val(act_key_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  logic [31:0] wk [NW][8];
  logic [31:0] ac [NW][8];
  logic [NW-1:0] m_hold, m_def;
  logic m_armed;

  function automatic logic [31:0] fmask(int w, int off);
    case (off)
      0: return 32'h0000_00F1;
      1: return 32'hFFFF_FFFF;
      2, 3: return 32'h0FFF_0FFF;
      4: return (w != 0) ? 32'h1 : 32'h0;
      5: return (w != 0) ? 32'h00FF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++)
        for (int o = 0; o < 8; o++) begin wk[w][o] = '0; ac[w][o] = '0; end
      m_hold = '0; m_def = '0; m_armed = 1'b0;
    end else begin
      logic [NW-1:0] nd;
      logic na;
      nd = m_def;
      if (vsync) begin
        for (int w = 0; w < NW; w++) begin
          if (m_armed || m_def[w]) begin
            if (m_hold[w]) nd[w] = 1'b1;
            else begin
              nd[w] = 1'b0;
              for (int o = 0; o < 8; o++) ac[w][o] = wk[w][o];
            end
          end
        end
      end
      na = vsync ? 1'b0 : m_armed;
      if (wr_en && !wr_addr[5]) begin
        if (wr_addr[4:3] < NW)
          wk[wr_addr[4:3]][wr_addr[2:0]] = wr_data & fmask(int'(wr_addr[4:3]), int'(wr_addr[2:0]));
        else if (wr_addr[4:3] == 2'd3) begin
          if (wr_addr[2:0] == 3'd0) m_hold = wr_data[NW-1:0];
          if (wr_addr[2:0] == 3'd1 && wr_data[0]) na = 1'b1;
        end
      end
      m_def = nd; m_armed = na;
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    if (a[4:3] < NW) return a[5] ? ac[a[4:3]][a[2:0]] : wk[a[4:3]][a[2:0]];
    if (!a[5] && a[4:3] == 2'd3) begin
      if (a[2:0] == 3'd0) return {{(32-NW){1'b0}}, m_hold};
      if (a[2:0] == 3'd1) return {{(31-NW){1'b0}}, m_def, m_armed};
    end
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    for (int w = 0; w < NW; w++) begin
      chk("R1 active outputs vs model",
          {act_en[w], act_fmt[w*4+:4], act_base[w*32+:32], act_key_en[w]},
          {ac[w][0][0], ac[w][0][7:4], ac[w][1], ac[w][4][0]});
      chk("R1 active geometry vs model",
          {act_tlx[w*12+:12], act_tly[w*12+:12], act_brx[w*12+:12], act_bry[w*12+:12]},
          {ac[w][2][11:0], ac[w][2][27:16], ac[w][3][11:0], ac[w][3][27:16]});
      chk("R8 active key value vs model", 64'(act_key_val[w*24+:24]), 64'(ac[w][5][23:0]));
    end
    chk("R7 read data vs model", 64'(rd_data), 64'(exp_rd(rd_addr)));
  end

  task automatic wr(logic [5:0] a, logic [31:0] d, logic vs = 1'b0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk); #1;
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic vs_pulse();
    @(posedge clk); #1; vsync = 1'b1;
    @(posedge clk); #1; vsync = 1'b0;
  endtask

  task automatic chk_rd(string tag, logic [5:0] a, logic [31:0] e);
    rd_addr = a; #1;
    chk(tag, 64'(rd_data), 64'(e));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vsync = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 act_en", 64'(act_en), 64'(0));
    chk("R10 act_base", 64'(act_base), 64'(0));
    chk_rd("R10 status", 6'h19, 32'h0);
    chk_rd("R10 hold", 6'h18, 32'h0);

    // write window 0 fields
    wr(6'h00, 32'h31);
    wr(6'h01, 32'h8000_1000);
    wr(6'h02, 32'h0020_0010);
    wr(6'h03, 32'h00FF_013F);
    chk("R1 no load before vsync", 64'(act_en), 64'(0));
    chk_rd("R7 working ctrl", 6'h00, 32'h31);
    chk_rd("R7 active ctrl", 6'h20, 32'h0);

    vs_pulse();
    chk("R3 unarmed vsync", 64'(act_en), 64'(0));

    wr(6'h19, 32'h1);
    chk_rd("R2 armed readback", 6'h19, 32'h1);
    vs_pulse();
    chk("R2 window 0 loaded", 64'(act_en), 64'(2'b01));
    chk("R2 base loaded", 64'(act_base[31:0]), 64'h8000_1000);
    chk("R7 bottom-right x", 64'(act_brx[11:0]), 64'h13F);
    chk_rd("R2 armed clears", 6'h19, 32'h0);
    chk_rd("R7 active base", 6'h21, 32'h8000_1000);

    // hold window 1
    wr(6'h18, 32'h2);
    wr(6'h08, 32'h51);
    wr(6'h19, 32'h1);
    vs_pulse();
    chk("R4 held window not loaded", 64'(act_en[1]), 64'(0));
    chk_rd("R4 deferred flag", 6'h19, 32'h4);
    vs_pulse();
    chk("R4 still held", 64'(act_en[1]), 64'(0));
    wr(6'h18, 32'h0);
    chk_rd("R5 flag kept until vsync", 6'h19, 32'h4);
    vs_pulse();
    chk("R5 deferred loads", 64'(act_en), 64'(2'b11));
    chk("R5 format loaded", 64'(act_fmt[7:4]), 64'h5);
    chk_rd("R5 flag cleared", 6'h19, 32'h0);

    // disable window 0
    wr(6'h00, 32'h30);
    chk("R6 enable held", 64'(act_en[0]), 64'(1));
    repeat (3) @(posedge clk);
    #1 chk("R6 enable held later", 64'(act_en[0]), 64'(1));
    wr(6'h19, 32'h1);
    vs_pulse();
    chk("R6 disabled at vsync", 64'(act_en[0]), 64'(0));

    // colour key
    wr(6'h04, 32'h1);
    wr(6'h05, 32'hABC);
    chk_rd("R8 w0 key ctrl", 6'h04, 32'h0);
    chk_rd("R8 w0 key value", 6'h05, 32'h0);
    wr(6'h0C, 32'h1);
    wr(6'h0D, 32'h0012_3456);
    chk_rd("R8 w1 key value", 6'h0D, 32'h0012_3456);
    wr(6'h19, 32'h1);
    vs_pulse();
    chk("R8 key enable", 64'(act_key_en), 64'(2'b10));
    chk("R8 key value", 64'(act_key_val[47:24]), 64'h12_3456);

    // writes into the active view are ignored
    wr(6'h21, 32'hDEAD);
    chk_rd("R11 working unchanged", 6'h01, 32'h8000_1000);
    chk_rd("R11 active unchanged", 6'h21, 32'h8000_1000);

    // write coincident with vsync
    wr(6'h19, 32'h1);
    wr(6'h01, 32'h9000_2000, 1'b1);
    chk("R9 old value transferred", 64'(act_base[31:0]), 64'h8000_1000);
    chk_rd("R9 working takes new", 6'h01, 32'h9000_2000);
    chk_rd("R9 arm consumed", 6'h19, 32'h0);
    wr(6'h19, 32'h1);
    vs_pulse();
    chk("R9 new value next vsync", 64'(act_base[31:0]), 64'h9000_2000);

    // arm coincident with vsync
    wr(6'h19, 32'h1, 1'b1);
    chk_rd("R9 arm survives vsync", 6'h19, 32'h1);
    vs_pulse();
    chk_rd("R9 arm used next vsync", 6'h19, 32'h0);

    repeat (2) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule